// File: doc/BRIEF.md
# Cache Line Refill Controller with Critical-Word Forwarding

This block services one cache miss at a time. It fetches an entire line of `WORDS` words from a memory port. The memory port takes one word-address request per handshake and returns one data word per beat. Responses come back in the order the requests were issued.

The order of the fetch is chosen per miss. In wrap-around mode the missed word is requested first, and the other words follow in increasing offset, wrapping at the end of the line. In ascending mode the words are requested from offset 0 upward. In both modes the missed word is handed to the processor in the same cycle its beat arrives, so the processor can continue while the line is still filling. The remaining beats are collected in a line buffer. When the last beat has been received, the whole line is written to the cache array in one single-cycle operation. Only then does the controller accept the next miss.

Top module: `refill_cwf_unit`

## Requirements
- R1: After reset, `miss_ready` is 1 and `mem_req_valid`, `cpu_rsp_valid` and `line_wr_valid` are 0.
- R2: When `miss_mode` is 1 at acceptance (wrap-around mode), the k-th request (k = 0..WORDS-1) carries the address {line, (offset + k) mod WORDS}. Here line is `miss_addr[ADDR_W-1:3]` and offset is `miss_addr[2:0]`.
- R3: When `miss_mode` is 0 at acceptance (ascending mode), the k-th request carries the address {line, k}.
- R4: For each miss, `cpu_rsp_valid` is high for exactly one cycle. That cycle is the cycle in which the beat holding the missed word is present on `mem_rsp_data`, and `cpu_rsp_data` equals that beat.
- R5: The missed word is forwarded on response beat 1 (counting from 1) in wrap-around mode, and on beat offset+1 in ascending mode.
- R6: `line_wr_valid` is high for one cycle, in the cycle after the last beat. `line_wr_addr` is the line address, and word i of the line sits in `line_wr_data[i*DATA_W +: DATA_W]`.
- R7: `miss_ready` is 0 from the cycle after acceptance through the line-write cycle, and returns to 1 in the next cycle. A miss presented while busy is not accepted.
- R8: `miss_mode` is sampled only at acceptance. Changing it during a refill does not change the request order.
- R9: A `mem_rsp_valid` beat arriving while no refill is in progress produces no CPU response and does not alter the next line.
- R10: Exactly WORDS requests are issued per miss, and none while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Controller idle, miss can be accepted |
| miss_addr | input | ADDR_W | Word address of the missed word |
| miss_mode | input | 1 | 1 = wrap-around from missed word, 0 = ascending |
| mem_req_valid | output | 1 | Word request to memory |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Requested word address |
| mem_rsp_valid | input | 1 | Returned data beat |
| mem_rsp_data | input | DATA_W | Returned word |
| cpu_rsp_valid | output | 1 | Missed word delivered to the processor |
| cpu_rsp_data | output | DATA_W | Missed word |
| line_wr_valid | output | 1 | Completed line write to the cache |
| line_wr_addr | output | ADDR_W-3 | Line address |
| line_wr_data | output | WORDS*DATA_W | Assembled line |

## Verification
The CPU response is combinational from the beat, so the bench looks for it in the same cycle the beat is driven. The bench also checks that the beat's position within the refill is 1 or offset+1, depending on the mode. The line write is due one clock after the last beat, and `miss_ready` is due one clock after that. Request addresses are compared at every accepted handshake against a queue the driver filled before raising the miss. The memory model answers each request exactly two cycles later, under a ready pattern that stalls periodically. All outputs are sampled shortly after the falling edge, when the values that the next rising edge will act on are settled.

// File: rtl/refill_pkg.sv
package refill_pkg;

  typedef enum logic {
    MODE_ASCEND = 1'b0,
    MODE_WRAP   = 1'b1
  } fill_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WRITE = 2'd2
  } fill_state_e;

endpackage

// File: rtl/refill_order.sv
module refill_order
  import refill_pkg::*;
#(
  parameter int WORDS = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  fill_mode_e       mode,
  input  logic [OFF_W-1:0] crit,
  input  logic [OFF_W-1:0] idx,
  output logic [OFF_W-1:0] off
);

  // Position of the idx-th word of a burst inside the line.
  // WORDS is a power of two, so the OFF_W-bit sum wraps modulo the line size.
  function automatic logic [OFF_W-1:0] word_order(input fill_mode_e m,
                                                  input logic [OFF_W-1:0] c,
                                                  input logic [OFF_W-1:0] k);
    if (m == MODE_WRAP) return c + k;
    return k;
  endfunction

  assign off = word_order(mode, crit, idx);

endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
#(
  parameter int WORDS = 8,
  localparam int OFF_W = $clog2(WORDS),
  localparam int CNT_W = OFF_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_fire,
  input  logic             req_fire,
  input  logic             beat_fire,
  output fill_state_e      state,
  output logic             req_open,
  output logic [OFF_W-1:0] req_idx,
  output logic [OFF_W-1:0] rsp_idx,
  output logic             first_beat,
  output logic             last_beat
);

  fill_state_e      state_q;
  logic [CNT_W-1:0] req_cnt;
  logic [OFF_W-1:0] rsp_cnt;

  assign last_beat  = beat_fire && (rsp_cnt == OFF_W'(WORDS - 1));
  assign first_beat = beat_fire && (rsp_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (miss_fire) state_q <= ST_FETCH;
        ST_FETCH: if (last_beat) state_q <= ST_WRITE;
        ST_WRITE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_cnt <= '0;
      rsp_cnt <= '0;
    end else if (miss_fire) begin
      req_cnt <= '0;
      rsp_cnt <= '0;
    end else begin
      if (req_fire)  req_cnt <= req_cnt + 1'b1;
      if (beat_fire) rsp_cnt <= rsp_cnt + 1'b1;
    end
  end

  assign state    = state_q;
  assign req_open = (state_q == ST_FETCH) && (req_cnt < CNT_W'(WORDS));
  assign req_idx  = req_cnt[OFF_W-1:0];
  assign rsp_idx  = rsp_cnt;

endmodule

// File: rtl/refill_linebuf.sv
module refill_linebuf #(
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [OFF_W-1:0]        wr_off,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [WORDS*DATA_W-1:0] line
);

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_off == OFF_W'(g))) word_q <= wr_data;
    end
    assign line[g*DATA_W +: DATA_W] = word_q;
  end

endmodule

// File: rtl/refill_cwf_unit.sv
module refill_cwf_unit
  import refill_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 8,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int LINE_AW = ADDR_W - OFF_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    miss_valid,
  output logic                    miss_ready,
  input  logic [ADDR_W-1:0]       miss_addr,
  input  logic                    miss_mode,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [DATA_W-1:0]       mem_rsp_data,
  output logic                    cpu_rsp_valid,
  output logic [DATA_W-1:0]       cpu_rsp_data,
  output logic                    line_wr_valid,
  output logic [LINE_AW-1:0]      line_wr_addr,
  output logic [WORDS*DATA_W-1:0] line_wr_data
);

  // Named internal events, also used by the bound checker
  logic             miss_fire;
  logic             req_fire;
  logic             beat_fire;
  logic             crit_hit;
  logic             first_beat;
  logic             first_beat_wrap;
  logic             last_beat;
  logic             req_open;

  fill_state_e      state;
  fill_mode_e       mode_q;
  logic [LINE_AW-1:0] line_q;
  logic [OFF_W-1:0] crit_q;
  logic [OFF_W-1:0] req_idx;
  logic [OFF_W-1:0] rsp_idx;
  logic [OFF_W-1:0] req_off;
  logic [OFF_W-1:0] rsp_off;

  assign miss_ready = (state == ST_IDLE);
  assign miss_fire  = miss_valid && miss_ready;
  assign req_fire   = mem_req_valid && mem_req_ready;
  assign beat_fire  = mem_rsp_valid && (state == ST_FETCH);

  // Miss context captured once, at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      crit_q <= '0;
      mode_q <= MODE_ASCEND;
    end else if (miss_fire) begin
      line_q <= miss_addr[ADDR_W-1:OFF_W];
      crit_q <= miss_addr[OFF_W-1:0];
      mode_q <= fill_mode_e'(miss_mode);
    end
  end

  refill_ctrl #(.WORDS(WORDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_fire  (miss_fire),
    .req_fire   (req_fire),
    .beat_fire  (beat_fire),
    .state      (state),
    .req_open   (req_open),
    .req_idx    (req_idx),
    .rsp_idx    (rsp_idx),
    .first_beat (first_beat),
    .last_beat  (last_beat)
  );

  // One order generator for the request stream and one for the returning beats
  refill_order #(.WORDS(WORDS)) u_req_order (
    .mode (mode_q),
    .crit (crit_q),
    .idx  (req_idx),
    .off  (req_off)
  );

  refill_order #(.WORDS(WORDS)) u_rsp_order (
    .mode (mode_q),
    .crit (crit_q),
    .idx  (rsp_idx),
    .off  (rsp_off)
  );

  assign mem_req_valid = req_open;
  assign mem_req_addr  = {line_q, req_off};

  // Forwarding path: the missed word passes straight through on its beat
  assign crit_hit        = beat_fire && (rsp_off == crit_q);
  assign first_beat_wrap = first_beat && (mode_q == MODE_WRAP);
  assign cpu_rsp_valid   = crit_hit;
  assign cpu_rsp_data    = mem_rsp_data;

  refill_linebuf #(.WORDS(WORDS), .DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .wr_en   (beat_fire),
    .wr_off  (rsp_off),
    .wr_data (mem_rsp_data),
    .line    (line_wr_data)
  );

  assign line_wr_valid = (state == ST_WRITE);
  assign line_wr_addr  = line_q;

endmodule

// File: rtl/refill_cwf_chk.sv
module refill_cwf_chk #(
  parameter int WORDS = 8,
  localparam int CNT_W = $clog2(WORDS) + 1
) (
  input logic clk,
  input logic rst_n,
  input logic miss_fire,
  input logic miss_ready,
  input logic mem_req_valid,
  input logic req_fire,
  input logic first_beat_wrap,
  input logic crit_hit,
  input logic cpu_rsp_valid,
  input logic line_wr_valid,
  input logic last_beat
);

  logic             fwd_seen;
  logic [CNT_W-1:0] req_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_seen <= 1'b0;
      req_seen <= '0;
    end else if (miss_fire) begin
      fwd_seen <= 1'b0;
      req_seen <= '0;
    end else begin
      if (crit_hit) fwd_seen <= 1'b1;
      if (req_fire) req_seen <= req_seen + 1'b1;
    end
  end

  a_r7_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    miss_fire |=> !miss_ready);

  a_r7_ready_back: assert property (@(posedge clk) disable iff (!rst_n)
    line_wr_valid |=> miss_ready);

  a_r6_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    line_wr_valid |=> !line_wr_valid);

  a_r6_write_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> line_wr_valid);

  a_r10_no_idle_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !miss_ready);

  a_r10_req_limit: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> (req_seen < CNT_W'(WORDS)));

  a_r5_wrap_first: assert property (@(posedge clk) disable iff (!rst_n)
    first_beat_wrap |-> crit_hit);

  a_r4_fwd_once: assert property (@(posedge clk) disable iff (!rst_n)
    crit_hit |-> !fwd_seen);

  a_r4_fwd_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    line_wr_valid |-> fwd_seen);

  a_r9_no_idle_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> !miss_ready);

endmodule

bind refill_cwf_unit refill_cwf_chk #(.WORDS(WORDS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .miss_fire       (miss_fire),
  .miss_ready      (miss_ready),
  .mem_req_valid   (mem_req_valid),
  .req_fire        (req_fire),
  .first_beat_wrap (first_beat_wrap),
  .crit_hit        (crit_hit),
  .cpu_rsp_valid   (cpu_rsp_valid),
  .line_wr_valid   (line_wr_valid),
  .last_beat       (last_beat)
);

// File: tb/tb_refill_cwf_unit.sv
module tb_refill_cwf_unit;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int WORDS  = 8;
  localparam int LAT    = 2;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    miss_valid = 1'b0;
  logic                    miss_ready;
  logic [ADDR_W-1:0]       miss_addr = '0;
  logic                    miss_mode = 1'b0;
  logic                    mem_req_valid;
  logic                    mem_req_ready = 1'b0;
  logic [ADDR_W-1:0]       mem_req_addr;
  logic                    mem_rsp_valid = 1'b0;
  logic [DATA_W-1:0]       mem_rsp_data = '0;
  logic                    cpu_rsp_valid;
  logic [DATA_W-1:0]       cpu_rsp_data;
  logic                    line_wr_valid;
  logic [ADDR_W-4:0]       line_wr_addr;
  logic [WORDS*DATA_W-1:0] line_wr_data;

  always #2.5 clk = ~clk;

  refill_cwf_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int beats = 0;
  bit bench_busy = 0;
  bit inject = 0;

  // Scoreboard queues
  logic [ADDR_W-1:0]       exp_req_addr[$];
  bit                      exp_req_wrap[$];
  logic [DATA_W-1:0]       exp_cpu_data[$];
  int                      exp_cpu_beat[$];
  logic [ADDR_W-4:0]       exp_line_addr[$];
  logic [WORDS*DATA_W-1:0] exp_line_data[$];
  logic [ADDR_W-1:0]       pend_addr[$];
  int                      pend_due[$];

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return {~a, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Memory model: fixed latency, in-order, periodic backpressure
  always @(negedge clk) begin
    cyc++;
    mem_req_ready = (cyc % 5) != 3;
    if (pend_due.size() > 0 && pend_due[0] <= cyc) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem_word(pend_addr[0]);
      void'(pend_addr.pop_front());
      void'(pend_due.pop_front());
    end else if (inject) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 32'hDEAD_BEEF;
    end else begin
      mem_rsp_valid = 1'b0;
    end
    if (cyc > 20000) begin
      chk(1'b0, "watchdog", cyc, 20000);
      summary();
    end
  end

  // Monitor: observes settled values ahead of the next rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (miss_valid && miss_ready) begin
        chk(!bench_busy, "R7 accepted while busy", 1, 0);
        bench_busy = 1;
        beats = 0;
      end else if (bench_busy) begin
        chk(!miss_ready, "R7 ready low during refill", miss_ready, 0);
      end
      if (mem_req_valid && mem_req_ready) begin
        if (exp_req_addr.size() == 0) begin
          chk(1'b0, "R10 unexpected request", mem_req_addr, 0);
        end else begin
          chk(mem_req_addr == exp_req_addr[0],
              exp_req_wrap[0] ? "R2 wrap order" : "R3 ascending order",
              mem_req_addr, exp_req_addr[0]);
          void'(exp_req_addr.pop_front());
          void'(exp_req_wrap.pop_front());
        end
        pend_addr.push_back(mem_req_addr);
        pend_due.push_back(cyc + LAT);
      end
      if (mem_rsp_valid && bench_busy && !(miss_valid && miss_ready)) beats++;
      if (cpu_rsp_valid) begin
        if (exp_cpu_data.size() == 0 || !bench_busy) begin
          chk(1'b0, "R9 R4 unexpected cpu response", cpu_rsp_data, 0);
        end else begin
          chk(cpu_rsp_data == exp_cpu_data[0], "R4 forwarded word", cpu_rsp_data,
              exp_cpu_data[0]);
          chk(beats == exp_cpu_beat[0], "R5 beats to critical word", beats,
              exp_cpu_beat[0]);
          void'(exp_cpu_data.pop_front());
          void'(exp_cpu_beat.pop_front());
        end
      end
      if (line_wr_valid) begin
        if (exp_line_addr.size() == 0) begin
          chk(1'b0, "R6 unexpected line write", line_wr_addr, 0);
        end else begin
          chk(beats == WORDS, "R6 write after last beat", beats, WORDS);
          chk(line_wr_addr == exp_line_addr[0], "R6 line address", line_wr_addr,
              exp_line_addr[0]);
          chk(line_wr_data == exp_line_data[0], "R6 R9 line data", line_wr_data,
              exp_line_data[0]);
          chk(exp_cpu_data.size() == 0, "R4 word forwarded before write",
              exp_cpu_data.size(), 0);
          void'(exp_line_addr.pop_front());
          void'(exp_line_data.pop_front());
        end
        bench_busy = 0;
      end
    end
  end

  // Driver: pushes expectations, then presents the miss
  task automatic do_miss(input logic [ADDR_W-1:0] a, input bit wrap, input bit flip,
                         input bit spam);
    logic [ADDR_W-4:0]       ln;
    logic [WORDS*DATA_W-1:0] ld;
    int                      c;
    ln = a[ADDR_W-1:3];
    c  = int'(a[2:0]);
    for (int k = 0; k < WORDS; k++) begin
      int o;
      o = wrap ? (c + k) % WORDS : k;
      exp_req_addr.push_back({ln, 3'(o)});
      exp_req_wrap.push_back(wrap);
    end
    exp_cpu_data.push_back(mem_word(a));
    exp_cpu_beat.push_back(wrap ? 1 : c + 1);
    for (int i = 0; i < WORDS; i++) ld[i*DATA_W +: DATA_W] = mem_word({ln, 3'(i)});
    exp_line_addr.push_back(ln);
    exp_line_data.push_back(ld);

    @(negedge clk);
    miss_valid = 1'b1;
    miss_addr  = a;
    miss_mode  = wrap;
    #1;
    while (!miss_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    miss_valid = 1'b0;
    if (flip) miss_mode = !wrap;           // R8: late mode change
    if (spam) begin                        // R7: miss offered while busy
      miss_valid = 1'b1;
      miss_addr  = a ^ 16'h0150;
      repeat (4) @(negedge clk);
      miss_valid = 1'b0;
    end
    while (bench_busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(miss_ready == 1'b1, "R1 ready after reset", miss_ready, 1);
    chk(mem_req_valid == 1'b0, "R1 no request in reset", mem_req_valid, 0);
    chk(cpu_rsp_valid == 1'b0, "R1 no cpu response in reset", cpu_rsp_valid, 0);
    chk(line_wr_valid == 1'b0, "R1 no line write in reset", line_wr_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;

    do_miss(16'h1230, 1'b1, 1'b0, 1'b0);   // R2 offset 0
    do_miss(16'h4563, 1'b1, 1'b0, 1'b0);   // R2 offset 3
    do_miss(16'h789F, 1'b1, 1'b0, 1'b0);   // R2 offset 7, wrap right away
    do_miss(16'h0AB8, 1'b0, 1'b0, 1'b0);   // R3 offset 0
    do_miss(16'h0CD5, 1'b0, 1'b0, 1'b0);   // R3 offset 5
    do_miss(16'hFFFF, 1'b0, 1'b0, 1'b0);   // R3 offset 7, last beat
    do_miss(16'h2226, 1'b1, 1'b1, 1'b0);   // R8 wrap, mode flipped mid-refill
    do_miss(16'h3332, 1'b0, 1'b1, 1'b0);   // R8 ascending, mode flipped
    do_miss(16'h5554, 1'b1, 1'b0, 1'b1);   // R7 busy miss ignored
    do_miss(16'h6661, 1'b0, 1'b0, 1'b1);   // R7 busy miss ignored

    // R9: stray beats while idle
    @(negedge clk);
    inject = 1'b1;
    repeat (3) @(negedge clk);
    inject = 1'b0;
    do_miss(16'h7774, 1'b0, 1'b0, 1'b0);   // R9 line unaffected by stray beats
    do_miss(16'h8882, 1'b1, 1'b0, 1'b0);

    repeat (5) @(negedge clk);
    #3;
    chk(exp_req_addr.size() == 0, "R10 all requests issued", exp_req_addr.size(), 0);
    chk(exp_line_addr.size() == 0, "R6 all lines written", exp_line_addr.size(), 0);
    chk(miss_ready == 1'b1, "R7 ready when idle", miss_ready, 1);
    chk(mem_req_valid == 1'b0, "R10 no request when idle", mem_req_valid, 0);
    summary();
  end

endmodule